// File: doc/BRIEF.md
# Video Encoder Control Register File with Two-Wire Serial Slave

This block holds the control state of a composite video encoder and lets a host microcontroller load and inspect it over a two-wire serial bus of the I2C kind. It runs entirely on the 27 MHz encoder clock. The serial clock and data lines are brought into that domain through flop synchronisers, and the data line is driven only through an open-drain pull-down enable. The block answers a single 7-bit device address. After the address, the first byte written sets an 8-bit register pointer. Every data byte then either lands in the register the pointer selects or is returned from it, and the pointer steps forward after each byte.

The 39 byte locations cover the mode/standard control byte, a configuration byte, an 11-bit sync delay, the 22-bit subcarrier increment and phase offset, three 8-entry 6-bit colour tables (luma and both colour differences), a test byte, a read-only status byte and a 20-bit line-forcing pair. Each location has its own storage width and read-back format. The status byte combines two live flags with a copy of the control byte. Writing the software-reset bit launches a fixed-length internal reset pulse, and the bit clears itself when the bus transaction ends. All stored fields are presented continuously on parallel output ports for the encoder datapath.

Top module: `vid_enc_regfile`

## Requirements
- R1: Only address bytes whose upper seven bits equal 1011000 (B0h to write, B1h to read) are acknowledged. Any other address gets no acknowledge, and the bytes that follow it change no register.
- R2: In a write, the slave acknowledges the address, the pointer byte and every data byte. Consecutive data bytes go to consecutive register indices starting at the pointer value.
- R3: After the pointer has been set by a write, a read transfer (new START and B1h) returns consecutive registers from the pointer onwards. It stops when the host does not acknowledge a byte.
- R4: On the synchronous reset every register takes its default value. All are 00h except: index 3 = 20h; indices 4..6 = 0Ah, 82h, 63h; indices 10..17 = 3Bh, 28h, 14h, 10h, 21h, 1Dh, 09h, 04h; indices 18..25 = 20h, 23h, 31h, 35h, 0Bh, 0Eh, 1Ch, 20h; indices 26..33 = 20h, 0Bh, 2Eh, 19h, 27h, 12h, 35h, 20h; index 37 = 40h.
- R5: The control byte (index 0) drives the outputs as follows: bits 7:6 standard select, bit 5 free-run enable, bit 4 slave sync source, bit 3 composite-sync polarity, bit 2 field polarity, bit 0 master select. The other outputs carry the rest: cfg = index 1; sync delay = {index 2, index 3 bits 7:5}; subcarrier increment = {index 4 bits 5:0, index 5, index 6}; phase offset = {index 7 bits 5:0, index 8, index 9}; test = index 34; line-forcing value = {index 36, index 37 bits 7:6}; line-match = {index 37 bits 5:0, index 38 bits 7:4}; colour-table entry e of each table is bits 5:0 of index (base + 7 - e), with bases 10, 18 and 26.
- R6: A data byte written to index 0 with bit 1 set raises the soft-reset output for exactly 4 clock cycles, provided no pulse is already running.
- R7: Control bit 1 reads back as 1 until the next STOP condition and as 0 afterwards.
- R8: Index 3 stores only bits 7:5. A read of index 3 returns those bits above bits 4:0 of index 2.
- R9: Colour-table indices 10..33 store 6 bits. A read returns bit 5 repeated in bits 7 and 6.
- R10: Index 35 is read-only. It reads as {hamming-ok input, frame-lock input, control bits 7:2}, and writing it has no effect.
- R11: A pointer above 38 is still acknowledged. Writes there are discarded and reads there return 00h.
- R12: Indices 4 and 7 store bits 5:0 only, and index 38 stores bits 7:4 only. The bits not stored read as 0.
- R13: The slave changes its data-line enable only while the synchronised serial clock is low, except when it releases the line after a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz encoder clock |
| rst | input | 1 | Synchronous active-high hard reset |
| scl_i | input | 1 | Serial clock line (asynchronous) |
| sda_i | input | 1 | Serial data line as seen on the bus (asynchronous) |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| hok_i | input | 1 | Hamming check status flag shown in status byte |
| lock_i | input | 1 | Frame-lock status flag shown in status byte |
| std_sel_o | output | 2 | Video standard select |
| freerun_en_o | output | 1 | Free-run enable |
| sync_src_o | output | 1 | Slave sync source select |
| csync_pol_o | output | 1 | Composite-sync output polarity |
| field_pol_o | output | 1 | Field signal polarity |
| master_o | output | 1 | Master mode select |
| soft_rst_o | output | 1 | Four-cycle internal reset pulse |
| cfg_o | output | 8 | Configuration byte |
| sync_delay_o | output | 11 | Sync delay counter value |
| sc_incr_o | output | 22 | Subcarrier phase increment |
| sc_offs_o | output | 22 | Subcarrier phase offset |
| clut_y_o | output | 48 | Luma colour table, entry e in bits 6e+5:6e |
| clut_cr_o | output | 48 | Red-difference colour table |
| clut_cb_o | output | 48 | Blue-difference colour table |
| test_o | output | 8 | Test byte |
| lf_val_o | output | 10 | Line-forcing load value |
| lc_val_o | output | 10 | Line-forcing match value |

## Verification
Both bus lines pass through two synchroniser flops and one edge-detect flop, so the slave moves its data-line enable three clocks after the SCL edge it reacts to. The bench holds every bus phase for six clocks and samples the acknowledge and read bits in the middle of the SCL high phase, well after that latency. A register write commits on the clock after the eighth falling SCL edge is detected, so the parallel outputs are compared only after the STOP, many cycles later. The soft-reset pulse is timed by a monitor that counts the high cycles sampled on falling clock edges and compares the run length with four.

// File: rtl/vre_pkg.sv
package vre_pkg;

    localparam int NUM_REGS   = 39;
    localparam int IDX_W      = $clog2(NUM_REGS);
    localparam int CLUT_N     = 8;
    localparam int CLUT_W     = 6;
    localparam int SRST_BIT   = 1;

    localparam int I_CTRL     = 0;
    localparam int I_DLY_HI   = 2;
    localparam int I_DLY_LO   = 3;
    localparam int I_INC_HI   = 4;
    localparam int I_OFS_HI   = 7;
    localparam int I_Y_BASE   = 10;
    localparam int I_CR_BASE  = 18;
    localparam int I_CB_BASE  = 26;
    localparam int I_CLUT_END = 33;
    localparam int I_STATUS   = 35;
    localparam int I_LC_LO    = 38;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_SUB, ST_SACK,
        ST_WDATA, ST_WACK, ST_RDATA, ST_RACK
    } bus_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic       en;
        logic [7:0] idx;
        logic [7:0] data;
    } wr_req_t;

    function automatic logic in_clut(input int idx);
        return (idx >= I_Y_BASE) && (idx <= I_CLUT_END);
    endfunction

    // bits each location actually stores
    function automatic logic [7:0] keep_mask(input int idx);
        if (idx == I_DLY_LO)                     return 8'hE0;
        if (idx == I_INC_HI || idx == I_OFS_HI)  return 8'h3F;
        if (in_clut(idx))                        return 8'h3F;
        if (idx == I_STATUS)                     return 8'h00;
        if (idx == I_LC_LO)                      return 8'hF0;
        return 8'hFF;
    endfunction

    function automatic logic [7:0] reset_value(input int idx);
        case (idx)
            3:  return 8'h20;
            4:  return 8'h0A;
            5:  return 8'h82;
            6:  return 8'h63;
            10: return 8'h3B;
            11: return 8'h28;
            12: return 8'h14;
            13: return 8'h10;
            14: return 8'h21;
            15: return 8'h1D;
            16: return 8'h09;
            17: return 8'h04;
            18: return 8'h20;
            19: return 8'h23;
            20: return 8'h31;
            21: return 8'h35;
            22: return 8'h0B;
            23: return 8'h0E;
            24: return 8'h1C;
            25: return 8'h20;
            26: return 8'h20;
            27: return 8'h0B;
            28: return 8'h2E;
            29: return 8'h19;
            30: return 8'h27;
            31: return 8'h12;
            32: return 8'h35;
            33: return 8'h20;
            37: return 8'h40;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/vre_bus_sync.sv
module vre_bus_sync
    import vre_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o,
    output logic     scl_s_o
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_d, sda_d;
    logic              scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_comb begin
        evt_o.start    = scl_s && scl_d && sda_d && !sda_s;
        evt_o.stop     = scl_s && scl_d && !sda_d && sda_s;
        evt_o.scl_rise = scl_s && !scl_d;
        evt_o.scl_fall = !scl_s && scl_d;
        evt_o.sda      = sda_s;
    end

    assign scl_s_o = scl_s;
endmodule

// File: rtl/vre_slave_fsm.sv
module vre_slave_fsm
    import vre_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h58
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_evt_t   evt_i,
    input  logic [7:0] rd_data_i,
    output logic [7:0] rd_idx_o,
    output wr_req_t    wr_o,
    output logic       sda_oe_o
);
    bus_state_e st;
    logic [3:0] bit_cnt;
    logic [7:0] rx_sh, tx_sh, ptr;
    logic       is_read, host_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            ptr      <= '0;
            is_read  <= 1'b0;
            host_ack <= 1'b0;
            sda_oe_o <= 1'b0;
            wr_o.en   <= 1'b0;
            wr_o.idx  <= '0;
            wr_o.data <= '0;
        end else begin
            wr_o.en <= 1'b0;
            if (evt_i.start) begin
                st       <= ST_ADDR;
                bit_cnt  <= '0;
                sda_oe_o <= 1'b0;
            end else if (evt_i.stop) begin
                st       <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR, ST_SUB, ST_WDATA: begin
                        if (evt_i.scl_rise && bit_cnt < 4'd8) begin
                            rx_sh   <= {rx_sh[6:0], evt_i.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (evt_i.scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (st == ST_ADDR) begin
                                if (rx_sh[7:1] == DEV_ADDR) begin
                                    sda_oe_o <= 1'b1;
                                    is_read  <= rx_sh[0];
                                    st       <= ST_AACK;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else if (st == ST_SUB) begin
                                ptr      <= rx_sh;
                                sda_oe_o <= 1'b1;
                                st       <= ST_SACK;
                            end else begin
                                wr_o.en   <= 1'b1;
                                wr_o.idx  <= ptr;
                                wr_o.data <= rx_sh;
                                ptr       <= ptr + 8'd1;
                                sda_oe_o  <= 1'b1;
                                st        <= ST_WACK;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (evt_i.scl_fall) begin
                            bit_cnt <= '0;
                            if (is_read) begin
                                tx_sh    <= rd_data_i;
                                sda_oe_o <= ~rd_data_i[7];
                                st       <= ST_RDATA;
                            end else begin
                                sda_oe_o <= 1'b0;
                                st       <= ST_SUB;
                            end
                        end
                    end
                    ST_SACK, ST_WACK: begin
                        if (evt_i.scl_fall) begin
                            sda_oe_o <= 1'b0;
                            bit_cnt  <= '0;
                            st       <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (evt_i.scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (evt_i.scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe_o <= 1'b0;
                                bit_cnt  <= '0;
                                st       <= ST_RACK;
                            end else if (bit_cnt != 4'd0) begin
                                tx_sh    <= {tx_sh[6:0], 1'b0};
                                sda_oe_o <= ~tx_sh[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (evt_i.scl_rise) begin
                            host_ack <= !evt_i.sda;
                            if (!evt_i.sda) ptr <= ptr + 8'd1;
                        end else if (evt_i.scl_fall) begin
                            if (host_ack) begin
                                tx_sh    <= rd_data_i;
                                sda_oe_o <= ~rd_data_i[7];
                                bit_cnt  <= '0;
                                st       <= ST_RDATA;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_idx_o = ptr;
endmodule

// File: rtl/vre_reg_bank.sv
module vre_reg_bank
    import vre_pkg::*;
#(
    parameter int SRST_CYCLES = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  wr_req_t                    wr_i,
    input  logic                       stop_i,
    input  logic [7:0]                 rd_idx_i,
    input  logic                       hok_i,
    input  logic                       lock_i,
    output logic [7:0]                 rd_data_o,
    output logic [NUM_REGS-1:0][7:0]   regs_o,
    output logic                       soft_rst_o
);
    localparam int CNT_W = $clog2(SRST_CYCLES + 1);

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        localparam logic [7:0] KEEP = keep_mask(gi);
        localparam logic [7:0] INIT = reset_value(gi);
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= INIT;
            else if (wr_i.en && wr_i.idx == 8'(gi))
                q <= wr_i.data & KEEP;
            else if (gi == I_CTRL && stop_i)
                q[SRST_BIT] <= 1'b0;
        end
        assign regs_o[gi] = q;
    end

    // read-back formatting per location
    logic [7:0] raw;
    always_comb begin
        raw       = regs_o[rd_idx_i[IDX_W-1:0]];
        rd_data_o = raw;
        if (rd_idx_i >= 8'(NUM_REGS))
            rd_data_o = 8'h00;
        else if (rd_idx_i == 8'(I_DLY_LO))
            rd_data_o = {raw[7:5], regs_o[I_DLY_HI][4:0]};
        else if (rd_idx_i == 8'(I_STATUS))
            rd_data_o = {hok_i, lock_i, regs_o[I_CTRL][7:2]};
        else if (rd_idx_i >= 8'(I_Y_BASE) && rd_idx_i <= 8'(I_CLUT_END))
            rd_data_o = {{2{raw[CLUT_W-1]}}, raw[CLUT_W-1:0]};
    end

    logic [CNT_W-1:0] srst_cnt;
    always_ff @(posedge clk) begin
        if (rst)
            srst_cnt <= '0;
        else if (wr_i.en && wr_i.idx == 8'(I_CTRL) && wr_i.data[SRST_BIT] && srst_cnt == '0)
            srst_cnt <= CNT_W'(SRST_CYCLES);
        else if (srst_cnt != '0)
            srst_cnt <= srst_cnt - 1'b1;
    end
    assign soft_rst_o = (srst_cnt != '0);
endmodule

// File: rtl/vid_enc_regfile.sv
module vid_enc_regfile
    import vre_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h58,
    parameter int         SYNC_STAGES = 2,
    parameter int         SRST_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    input  logic        hok_i,
    input  logic        lock_i,
    output logic [1:0]  std_sel_o,
    output logic        freerun_en_o,
    output logic        sync_src_o,
    output logic        csync_pol_o,
    output logic        field_pol_o,
    output logic        master_o,
    output logic        soft_rst_o,
    output logic [7:0]  cfg_o,
    output logic [10:0] sync_delay_o,
    output logic [21:0] sc_incr_o,
    output logic [21:0] sc_offs_o,
    output logic [47:0] clut_y_o,
    output logic [47:0] clut_cr_o,
    output logic [47:0] clut_cb_o,
    output logic [7:0]  test_o,
    output logic [9:0]  lf_val_o,
    output logic [9:0]  lc_val_o
);
    bus_evt_t                   bus_evt;
    logic                       scl_s;
    wr_req_t                    wr_req;
    logic [7:0]                 rd_idx, rd_data;
    logic [NUM_REGS-1:0][7:0]   regs;

    vre_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .evt_o   (bus_evt),
        .scl_s_o (scl_s)
    );

    vre_slave_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (bus_evt),
        .rd_data_i (rd_data),
        .rd_idx_o  (rd_idx),
        .wr_o      (wr_req),
        .sda_oe_o  (sda_oe_o)
    );

    vre_reg_bank #(.SRST_CYCLES(SRST_CYCLES)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (wr_req),
        .stop_i     (bus_evt.stop),
        .rd_idx_i   (rd_idx),
        .hok_i      (hok_i),
        .lock_i     (lock_i),
        .rd_data_o  (rd_data),
        .regs_o     (regs),
        .soft_rst_o (soft_rst_o)
    );

    assign std_sel_o    = regs[I_CTRL][7:6];
    assign freerun_en_o = regs[I_CTRL][5];
    assign sync_src_o   = regs[I_CTRL][4];
    assign csync_pol_o  = regs[I_CTRL][3];
    assign field_pol_o  = regs[I_CTRL][2];
    assign master_o     = regs[I_CTRL][0];
    assign cfg_o        = regs[1];
    assign sync_delay_o = {regs[I_DLY_HI], regs[I_DLY_LO][7:5]};
    assign sc_incr_o    = {regs[I_INC_HI][5:0], regs[I_INC_HI+1], regs[I_INC_HI+2]};
    assign sc_offs_o    = {regs[I_OFS_HI][5:0], regs[I_OFS_HI+1], regs[I_OFS_HI+2]};
    assign test_o       = regs[34];
    assign lf_val_o     = {regs[36], regs[37][7:6]};
    assign lc_val_o     = {regs[37][5:0], regs[I_LC_LO][7:4]};

    for (genvar e = 0; e < CLUT_N; e++) begin : g_clut
        assign clut_y_o [e*CLUT_W +: CLUT_W] = regs[I_Y_BASE  + CLUT_N - 1 - e][CLUT_W-1:0];
        assign clut_cr_o[e*CLUT_W +: CLUT_W] = regs[I_CR_BASE + CLUT_N - 1 - e][CLUT_W-1:0];
        assign clut_cb_o[e*CLUT_W +: CLUT_W] = regs[I_CB_BASE + CLUT_N - 1 - e][CLUT_W-1:0];
    end
endmodule

// File: rtl/vre_checker.sv
module vre_checker
    import vre_pkg::*;
#(
    parameter int SRST_CYCLES = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     scl_s,
    input logic                     start_evt,
    input logic                     stop_evt,
    input logic                     sda_oe,
    input logic                     soft_rst,
    input logic                     wr_en,
    input logic [7:0]               wr_idx,
    input logic [NUM_REGS-1:0][7:0] regs
);
    localparam int RW = $clog2(SRST_CYCLES + 1) + 1;
    logic [RW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)           run_cnt <= '0;
        else if (soft_rst) run_cnt <= run_cnt + 1'b1;
        else               run_cnt <= '0;
    end

    // R4: defaults present when reset is released
    a_r4_reset_state: assert property (@(posedge clk)
        $fell(rst) |-> (regs[10] == 8'h3B && regs[3] == 8'h20 && regs[5] == 8'h82
                        && !soft_rst && !sda_oe));

    // R6: pulse never longer than the configured length
    a_r6_srst_max: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> run_cnt < RW'(SRST_CYCLES));

    // R6: pulse ends exactly at the configured length
    a_r6_srst_len: assert property (@(posedge clk) disable iff (rst)
        $fell(soft_rst) |-> run_cnt == RW'(SRST_CYCLES));

    // R7: STOP clears the soft-reset request bit
    a_r7_stop_clears: assert property (@(posedge clk) disable iff (rst)
        (stop_evt && !wr_en) |=> !regs[0][SRST_BIT]);

    // R10: a write to the status location leaves storage untouched
    a_r10_status_ro: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == 8'(I_STATUS)) |=> regs == $past(regs));

    // R11: writes beyond the map are discarded
    a_r11_unmapped: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx >= 8'(NUM_REGS)) |=> regs == $past(regs));

    // R13: data-line enable moves only with SCL low, or on START/STOP release
    a_r13_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> (!scl_s || $past(start_evt) || $past(stop_evt)));
endmodule

bind vid_enc_regfile vre_checker #(.SRST_CYCLES(SRST_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .start_evt (bus_evt.start),
    .stop_evt  (bus_evt.stop),
    .sda_oe    (sda_oe_o),
    .soft_rst  (soft_rst_o),
    .wr_en     (wr_req.en),
    .wr_idx    (wr_req.idx),
    .regs      (regs)
);

// File: tb/vid_enc_regfile_bench.sv
module vid_enc_regfile_bench;
    localparam int H = 6;
    localparam int NR = 39;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda_low = 1'b0;
    logic hok = 1'b0, lock = 1'b0;
    logic sda_oe, sda_line;
    assign sda_line = ~(m_sda_low | sda_oe);

    logic [1:0]  std_sel;
    logic        freerun_en, sync_src, csync_pol, field_pol, master, soft_rst;
    logic [7:0]  cfg, test;
    logic [10:0] sync_delay;
    logic [21:0] sc_incr, sc_offs;
    logic [47:0] clut_y, clut_cr, clut_cb;
    logic [9:0]  lf_val, lc_val;

    vid_enc_regfile u_vid_enc_regfile (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .hok_i(hok), .lock_i(lock), .std_sel_o(std_sel), .freerun_en_o(freerun_en),
        .sync_src_o(sync_src), .csync_pol_o(csync_pol), .field_pol_o(field_pol),
        .master_o(master), .soft_rst_o(soft_rst), .cfg_o(cfg), .sync_delay_o(sync_delay),
        .sc_incr_o(sc_incr), .sc_offs_o(sc_offs), .clut_y_o(clut_y), .clut_cr_o(clut_cr),
        .clut_cb_o(clut_cb), .test_o(test), .lf_val_o(lf_val), .lc_val_o(lc_val)
    );

    int checks = 0, fails = 0;
    logic [7:0] exp_q [NR];
    logic [7:0] wbuf [8];

    // soft-reset pulse monitor
    int run = 0, last_run = 0, pulses = 0;
    always @(negedge clk) begin
        if (soft_rst) run++;
        else if (run != 0) begin last_run = run; pulses++; run = 0; end
    end

    function automatic logic [7:0] keep(input int i);
        if (i == 3) return 8'hE0;
        if (i == 4 || i == 7) return 8'h3F;
        if (i >= 10 && i <= 33) return 8'h3F;
        if (i == 35) return 8'h00;
        if (i == 38) return 8'hF0;
        return 8'hFF;
    endfunction

    function automatic logic [7:0] dflt(input int i);
        logic [7:0] yv [8] = '{8'h3B, 8'h28, 8'h14, 8'h10, 8'h21, 8'h1D, 8'h09, 8'h04};
        logic [7:0] rv [8] = '{8'h20, 8'h23, 8'h31, 8'h35, 8'h0B, 8'h0E, 8'h1C, 8'h20};
        logic [7:0] bv [8] = '{8'h20, 8'h0B, 8'h2E, 8'h19, 8'h27, 8'h12, 8'h35, 8'h20};
        if (i >= 10 && i <= 17) return yv[i-10];
        if (i >= 18 && i <= 25) return rv[i-18];
        if (i >= 26 && i <= 33) return bv[i-26];
        case (i)
            3: return 8'h20; 4: return 8'h0A; 5: return 8'h82; 6: return 8'h63;
            37: return 8'h40;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] rd_exp(input int i);
        if (i >= NR) return 8'h00;
        if (i == 3)  return {exp_q[3][7:5], exp_q[2][4:0]};
        if (i == 35) return {hok, lock, exp_q[0][7:2]};
        if (i >= 10 && i <= 33) return {{2{exp_q[i][5]}}, exp_q[i][5:0]};
        return exp_q[i];
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] expv);
        checks++;
        if (got !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda_low = 1'b0; tick(H);
        m_scl = 1'b1;     tick(H);
        m_sda_low = 1'b1; tick(H);
        m_scl = 1'b0;     tick(H);
    endtask

    task automatic i2c_stop();
        m_sda_low = 1'b1; tick(H);
        m_scl = 1'b1;     tick(H);
        m_sda_low = 1'b0; tick(H);
        exp_q[0][1] = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int k = 7; k >= 0; k--) begin
            m_sda_low = ~b[k]; tick(H);
            m_scl = 1'b1;      tick(H);
            m_scl = 1'b0;      tick(1);
        end
        m_sda_low = 1'b0; tick(H);
        m_scl = 1'b1; tick(H/2);
        acked = ~sda_line;
        tick(H/2);
        m_scl = 1'b0; tick(1);
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] b);
        m_sda_low = 1'b0;
        for (int k = 7; k >= 0; k--) begin
            tick(H); m_scl = 1'b1; tick(H/2);
            b[k] = sda_line;
            tick(H/2); m_scl = 1'b0;
        end
        tick(1); m_sda_low = ack; tick(H);
        m_scl = 1'b1; tick(H);
        m_scl = 1'b0; tick(1);
        m_sda_low = 1'b0;
    endtask

    task automatic wr_burst(input int sub, input int n);
        logic a;
        i2c_start();
        send_byte(8'hB0, a); check("R1 write address ack", a, 1'b1);
        send_byte(8'(sub), a);
        if (sub >= NR) check("R11 pointer ack beyond map", a, 1'b1);
        else           check("R2 pointer ack", a, 1'b1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a); check("R2 data ack", a, 1'b1);
            if (sub + i < NR) exp_q[sub+i] = wbuf[i] & keep(sub + i);
        end
        i2c_stop();
    endtask

    task automatic rd_burst(input int sub, input int n, input string req);
        logic a;
        logic [7:0] b;
        i2c_start();
        send_byte(8'hB0, a);
        send_byte(8'(sub), a);
        i2c_stop();
        i2c_start();
        send_byte(8'hB1, a); check("R3 read address ack", a, 1'b1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            check(req, b, rd_exp(sub + i));
        end
        i2c_stop();
    endtask

    task automatic check_fields(input string req);
        logic [47:0] ey, ecr, ecb;
        for (int e = 0; e < 8; e++) begin
            ey [e*6 +: 6] = exp_q[17-e][5:0];
            ecr[e*6 +: 6] = exp_q[25-e][5:0];
            ecb[e*6 +: 6] = exp_q[33-e][5:0];
        end
        check({req, " ctrl fields"},
              {std_sel, freerun_en, sync_src, csync_pol, field_pol, master},
              {exp_q[0][7:2], exp_q[0][0]});
        check({req, " cfg/test"}, {cfg, test}, {exp_q[1], exp_q[34]});
        check({req, " sync delay"}, sync_delay, {exp_q[2], exp_q[3][7:5]});
        check({req, " subcarrier"}, {sc_incr, sc_offs},
              {exp_q[4][5:0], exp_q[5], exp_q[6], exp_q[7][5:0], exp_q[8], exp_q[9]});
        check({req, " clut y"}, clut_y, ey);
        check({req, " clut cr/cb"}, {clut_cr, clut_cb}, {ecr, ecb});
        check({req, " line force"}, {lf_val, lc_val},
              {exp_q[36], exp_q[37], exp_q[38][7:4]});
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] b;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NR; i++) exp_q[i] = dflt(i);
        tick(5);
        rst = 1'b0;
        tick(3);

        // R4 reset state
        check("R4 sda released after reset", sda_oe, 1'b0);
        check("R4 no soft reset after reset", soft_rst, 1'b0);
        check("R4 default increment", sc_incr, 22'h0A8263);
        check_fields("R4 R5 defaults");
        rd_burst(0, NR, "R3 R4 R8 R9 default readback");

        // R1 foreign address: no ack, no effect
        i2c_start();
        send_byte(8'hA0, a); check("R1 foreign address nack", a, 1'b0);
        send_byte(8'h01, a);
        send_byte(8'hFF, a);
        i2c_stop();
        check_fields("R1 no change after foreign address");

        // R5 control byte fields
        wbuf[0] = 8'hF9; wr_burst(0, 1);
        check_fields("R5 control byte");

        // R6/R7 soft reset pulse and self-clear
        wbuf[0] = 8'h02; wr_burst(0, 0);
        i2c_start();
        send_byte(8'hB0, a); send_byte(8'h00, a);
        send_byte(8'h02, a); exp_q[0] = 8'h02;
        i2c_start();
        send_byte(8'hB0, a); send_byte(8'h00, a);
        i2c_start();
        send_byte(8'hB1, a);
        recv_byte(1'b0, b);
        check("R7 soft bit reads 1 before STOP", b, 8'h02);
        i2c_stop();
        tick(10);
        check("R6 soft reset pulse count", pulses, 1);
        check("R6 soft reset pulse length", last_run, 4);
        rd_burst(0, 1, "R7 soft bit cleared after STOP");

        // R8 delay low byte format
        wbuf[0] = 8'h5A; wbuf[1] = 8'hFF; wr_burst(2, 2);
        rd_burst(3, 1, "R8 delay low readback");
        check("R8 delay output", sync_delay, {8'h5A, 3'b111});

        // R9 colour table replication
        wbuf[0] = 8'hE5; wbuf[1] = 8'h1F; wbuf[2] = 8'hA0; wr_burst(10, 3);
        rd_burst(10, 3, "R9 clut readback");
        check_fields("R9 clut outputs");

        // R10 status read-only
        hok = 1'b1; lock = 1'b0;
        wbuf[0] = 8'hFF; wr_burst(35, 1);
        rd_burst(35, 1, "R10 status readback");
        hok = 1'b0; lock = 1'b1;
        rd_burst(34, 2, "R10 status with lock flag");

        // R11 beyond map, R12 partial locations
        wbuf[0] = 8'h11; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF; wbuf[3] = 8'h77;
        wr_burst(36, 4);
        rd_burst(36, 5, "R11 R12 tail of map");
        wbuf[0] = 8'hFF; wr_burst(4, 1);
        wbuf[0] = 8'hFF; wr_burst(7, 1);
        rd_burst(4, 4, "R12 six-bit subcarrier high bytes");
        check_fields("R11 R12 outputs");

        // random bursts (R2 R3)
        for (int it = 0; it < 24; it++) begin
            int sub, n;
            sub = int'($urandom_range(0, 42));
            n   = int'($urandom_range(1, 4));
            for (int i = 0; i < n; i++) begin
                wbuf[i] = 8'($urandom);
                if (sub + i == 0) wbuf[i][1] = 1'b0;
            end
            hok  = 1'($urandom);
            lock = 1'($urandom);
            wr_burst(sub, n);
            rd_burst(sub, n + 1, "R2 R3 random burst readback");
        end
        check_fields("R2 R5 random final outputs");
        check("R6 no extra soft reset pulses", pulses, 1);

        summary();
        $finish;
    end
endmodule